// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt inputs and presents a single interrupt line to a CPU. The CPU talks to it over a byte-wide write bus with one address bit, which selects an even or an odd port. Before it does anything, the controller must be configured by a short burst of command words. The first word goes to the even port, carries a marker bit, and restarts the whole sequence. Its fields pick edge or level detection, a 4-byte or 8-byte vector interval, single or cascaded operation, and whether a final word follows. The following words go to the odd port: the vector base, then a cascade word when cascaded, then the optional last word.

Once configured, odd-port writes load an interrupt mask. Even-port writes without the marker bit are end-of-interrupt commands. Requests are latched, filtered by the mask, and resolved with fixed priority against the bits already in service. When the CPU pulses its acknowledge input, the winning request moves into service. A vector byte then appears one cycle later, flagged by a valid strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the controller is unconfigured: `int_out` and `vec_vld` are low, and `int_out` stays low whatever the inputs do until a configuration sequence completes.
- R2: An even-port write with bit 4 set restarts configuration: mask, in-service and request state are cleared and `int_out` is low until the sequence ends. Bits 7:5 of that word have no effect. Bit 3 = level mode, bit 2 = 4-byte interval, bit 1 = single mode, bit 0 = final word follows.
- R3: The sequence length follows the first word. The second word (odd port) is always the vector base. In cascaded mode (bit 1 clear) one more odd-port word follows it. When bit 0 is set, one further odd-port word follows after that. The controller is ready after the last word.
- R4: In edge mode a 0-to-1 input transition latches a request. An input held high raises no new request after it has been serviced.
- R5: In level mode a request is present for as long as its input is high, so an input still high after its end-of-interrupt requests again.
- R6: Priority is fixed, with input 0 highest. An acknowledge while `int_out` is high moves the highest-priority unmasked request into service.
- R7: Vector byte: with the 8-byte interval it is {base[7:3], n}; with the 4-byte interval it is {base[7:5], n, 2'b00}, where n is the 3-bit input number.
- R8: `int_out` is high only when an unmasked request outranks every in-service input (nesting).
- R9: Writing 0x20 to the even port clears the highest-priority in-service bit.
- R10: Writing 0x60 | n to the even port clears in-service bit n only.
- R11: Odd-port writes after configuration load the mask; a set bit blocks that input from raising `int_out`, and clearing it lets a pending request through.
- R12: An acknowledge while `int_out` is low returns the vector for input 7 and changes no state.
- R13: `vec_vld` is high for exactly the cycle after an acknowledge, with `vec_out` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_a0 | input | 1 | Port select: 0 even, 1 odd |
| bus_wdata | input | 8 | Write data |
| irq_in | input | 8 | Interrupt inputs, index 0 highest priority |
| cpu_ack | input | 1 | Acknowledge pulse from the CPU |
| int_out | output | 1 | Interrupt request to the CPU |
| vec_out | output | 8 | Vector byte for the last acknowledge |
| vec_vld | output | 1 | Vector valid, cycle after acknowledge |

## Verification
The bench builds the block with its default eight inputs and 8-bit bus. This makes each of the eight priority levels, every mask pattern and both vector formats reachable within a few thousand cycles. A reference model runs random input toggles, acknowledges, mask writes and both kinds of end-of-interrupt command in edge mode and in level mode. It compares `int_out` and the vector every cycle. Directed sequences cover each configuration length, nesting, spurious acknowledge and ignored marker-word bits.

// File: rtl/pic_pkg.sv
// Shared constants and types for the priority interrupt controller.
// Assumes an 8-bit command bus; bit positions below are decoded by
// the configuration sequencer and the command decoder.
package pic_pkg;
    typedef enum logic [2:0] {
        ST_NOINIT,
        ST_BASE,
        ST_CASC,
        ST_LAST,
        ST_READY
    } init_st_e;

    localparam int CW1_FLAG_BIT  = 4;
    localparam int CW1_LEVEL_BIT = 3;
    localparam int CW1_IVAL4_BIT = 2;
    localparam int CW1_SNGL_BIT  = 1;
    localparam int CW1_LAST_BIT  = 0;

    localparam logic [7:0] EOI_NONSPEC = 8'h20;
    localparam logic [7:0] EOI_SPEC    = 8'h60;
endpackage

// File: rtl/pic_init_seq.sv
// Configuration sequencer: walks the command-word burst, holds the
// configuration fields and decodes post-configuration writes.
// Assumes one write per bus_wr pulse.
module pic_init_seq
    import pic_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_a0,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ready,
    output logic              restart,
    output logic              cfg_level,
    output logic              cfg_ival4,
    output logic [DATA_W-1:0] vec_base,
    output logic              mask_wr,
    output logic              cmd_wr
);
    init_st_e state;
    logic     cfg_single;
    logic     cfg_last;

    // Decode of the three kinds of write
    assign restart = bus_wr && !bus_a0 && bus_wdata[CW1_FLAG_BIT];
    assign ready   = (state == ST_READY);
    assign mask_wr = bus_wr && bus_a0 && ready;
    assign cmd_wr  = bus_wr && !bus_a0 && !bus_wdata[CW1_FLAG_BIT] && ready;

    // Sequence state and configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_NOINIT;
            cfg_level  <= 1'b0;
            cfg_ival4  <= 1'b0;
            cfg_single <= 1'b1;
            cfg_last   <= 1'b0;
            vec_base   <= '0;
        end else if (restart) begin
            state      <= ST_BASE;
            cfg_level  <= bus_wdata[CW1_LEVEL_BIT];
            cfg_ival4  <= bus_wdata[CW1_IVAL4_BIT];
            cfg_single <= bus_wdata[CW1_SNGL_BIT];
            cfg_last   <= bus_wdata[CW1_LAST_BIT];
        end else if (bus_wr && bus_a0) begin
            case (state)
                ST_BASE: begin
                    vec_base <= bus_wdata;
                    if (!cfg_single)   state <= ST_CASC;
                    else if (cfg_last) state <= ST_LAST;
                    else               state <= ST_READY;
                end
                ST_CASC: state <= cfg_last ? ST_LAST : ST_READY;
                ST_LAST: state <= ST_READY;
                default: state <= state;
            endcase
        end
    end

    // R2
    restart_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ready);
    // R3
    base_word_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BASE) && bus_wr && bus_a0 && !restart |=> state != ST_BASE);
endmodule

// File: rtl/pic_req_reg.sv
// Request latch: captures inputs as edges or levels and drops the
// bit taken by an acknowledge. Assumes inputs already synchronous.
module pic_req_reg #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_mode,
    input  logic               clr_all,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] ack_clr,
    output logic [NUM_IRQ-1:0] irr
);
    logic [NUM_IRQ-1:0] irq_q;

    // Previous input sample for edge detection, and the request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            irr   <= '0;
        end else begin
            irq_q <= irq_in;
            if (clr_all)         irr <= '0;
            else if (level_mode) irr <= irq_in & ~ack_clr;
            else                 irr <= (irr | (irq_in & ~irq_q)) & ~ack_clr;
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_edge_chk
        // R4
        edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !level_mode && !clr_all && irq_in[g] && !irq_q[g] && !ack_clr[g]
            |=> irr[g]);
    end
endmodule

// File: rtl/pic_prio.sv
// Fixed-priority resolver: index 0 wins. Finds the best pending
// request and the best in-service bit, and says whether the request
// may interrupt. Purely combinational.
module pic_prio #(
    parameter int NUM_IRQ = 8,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] isr,
    output logic               req_any,
    output logic [IDX_W-1:0]   req_idx,
    output logic               isr_any,
    output logic [IDX_W-1:0]   isr_idx,
    output logic               preempt
);
    // Scan from lowest priority up so the highest one is kept last
    always_comb begin
        req_idx = '0;
        isr_idx = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pend[i]) req_idx = IDX_W'(i);
            if (isr[i])  isr_idx = IDX_W'(i);
        end
    end

    assign req_any = |pend;
    assign isr_any = |isr;
    assign preempt = req_any && (!isr_any || (req_idx < isr_idx));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the priority interrupt controller: mask and in-service
// registers, acknowledge and end-of-interrupt handling, vector output.
// Assumes cpu_ack and bus_wr are single-cycle pulses.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_a0,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               cpu_ack,
    output logic               int_out,
    output logic [DATA_W-1:0]  vec_out,
    output logic               vec_vld
);
    localparam int IDX_W = $clog2(NUM_IRQ);
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(NUM_IRQ - 1);

    logic               ready, restart, cfg_level, cfg_ival4, mask_wr, cmd_wr;
    logic [DATA_W-1:0]  vec_base;
    logic [NUM_IRQ-1:0] irr, imr, isr, pend, ack_set, eoi_clr;
    logic               req_any, isr_any, preempt, ack_take;
    logic [IDX_W-1:0]   req_idx, isr_idx;

    pic_init_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_a0(bus_a0),
        .bus_wdata(bus_wdata), .ready(ready), .restart(restart),
        .cfg_level(cfg_level), .cfg_ival4(cfg_ival4), .vec_base(vec_base),
        .mask_wr(mask_wr), .cmd_wr(cmd_wr)
    );

    pic_req_reg #(.NUM_IRQ(NUM_IRQ)) u_req (
        .clk(clk), .rst_n(rst_n), .level_mode(cfg_level), .clr_all(restart),
        .irq_in(irq_in), .ack_clr(ack_set), .irr(irr)
    );

    pic_prio #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_prio (
        .pend(pend), .isr(isr), .req_any(req_any), .req_idx(req_idx),
        .isr_any(isr_any), .isr_idx(isr_idx), .preempt(preempt)
    );

    // Vector byte from base and input number, per interval setting
    function automatic logic [DATA_W-1:0] make_vec(input logic [DATA_W-1:0] base,
                                                   input logic ival4,
                                                   input logic [IDX_W-1:0] idx);
        if (ival4) return {base[DATA_W-1:IDX_W+2], idx, 2'b00};
        return {base[DATA_W-1:IDX_W], idx};
    endfunction

    // Request gating, interrupt line, acknowledge decode
    assign pend     = irr & ~imr;
    assign int_out  = ready && preempt;
    assign ack_take = cpu_ack && int_out;
    assign ack_set  = ack_take ? (NUM_IRQ'(1) << req_idx) : '0;

    // End-of-interrupt decode: non-specific or specific
    always_comb begin
        eoi_clr = '0;
        if (cmd_wr && bus_wdata == EOI_NONSPEC && isr_any)
            eoi_clr = NUM_IRQ'(1) << isr_idx;
        else if (cmd_wr && (bus_wdata >> IDX_W) == (EOI_SPEC >> IDX_W))
            eoi_clr = NUM_IRQ'(1) << bus_wdata[IDX_W-1:0];
    end

    // Mask and in-service registers
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            imr <= '0;
            isr <= '0;
        end else begin
            if (mask_wr) imr <= bus_wdata[NUM_IRQ-1:0];
            isr <= (isr | ack_set) & ~eoi_clr;
        end
    end

    // Vector register and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out <= '0;
            vec_vld <= 1'b0;
        end else begin
            vec_vld <= cpu_ack;
            if (cpu_ack)
                vec_out <= make_vec(vec_base, cfg_ival4, ack_take ? req_idx : SPUR_IDX);
        end
    end

    // R6
    ack_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take && !restart && !cmd_wr |=> $countones(isr) == $past($countones(isr)) + 1);
    // R9
    nonspec_eoi_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && bus_wdata == EOI_NONSPEC && isr_any && !cpu_ack
        |=> $countones(isr) == $past($countones(isr)) - 1);
    // R12
    spurious_ack_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack && !int_out && !bus_wr |=> $stable(isr));
    // R1
    noint_unconfigured_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(bus_wr));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_a0 = 1'b0, cpu_ack = 1'b0;
    logic [7:0] bus_wdata = '0, irq_in = '0;
    logic       int_out, vec_vld;
    logic [7:0] vec_out;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_a0(bus_a0),
        .bus_wdata(bus_wdata), .irq_in(irq_in), .cpu_ack(cpu_ack),
        .int_out(int_out), .vec_out(vec_out), .vec_vld(vec_vld)
    );

    // Reference model state (0 noinit, 1 base, 2 cascade, 3 last, 4 ready)
    int         m_st;
    logic       m_lvl, m_iv4, m_sng, m_lst;
    logic [7:0] m_base, m_irr, m_isr, m_imr, m_irqq;

    function automatic int lowbit(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic m_int();
        logic [7:0] p = m_irr & ~m_imr;
        return (m_st == 4) && (p != 0) && (m_isr == 0 || lowbit(p) < lowbit(m_isr));
    endfunction

    function automatic logic [7:0] vec_calc(input logic [7:0] b, input logic iv4, input int n);
        if (iv4) return {b[7:5], 3'(n), 2'b00};
        return {b[7:3], 3'(n)};
    endfunction

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // One clock: advance model with current inputs, then compare outputs
    task automatic tick();
        logic [7:0] ackm, irr_n, isr_n, vexp;
        logic       vld_exp, cur_int;
        cur_int = m_int();
        ackm = (cpu_ack && cur_int) ? (8'd1 << lowbit(m_irr & ~m_imr)) : 8'd0;
        vexp = vec_calc(m_base, m_iv4, cur_int ? lowbit(m_irr & ~m_imr) : 7);
        vld_exp = cpu_ack;
        irr_n = m_lvl ? (irq_in & ~ackm) : ((m_irr | (irq_in & ~m_irqq)) & ~ackm);
        isr_n = m_isr | ackm;
        if (bus_wr && !bus_a0 && bus_wdata[4]) begin
            m_st = 1; m_lvl = bus_wdata[3]; m_iv4 = bus_wdata[2];
            m_sng = bus_wdata[1]; m_lst = bus_wdata[0];
            m_imr = 0; isr_n = 0; irr_n = 0;
        end else if (bus_wr && bus_a0) begin
            case (m_st)
                1: begin m_base = bus_wdata; m_st = !m_sng ? 2 : (m_lst ? 3 : 4); end
                2: m_st = m_lst ? 3 : 4;
                3: m_st = 4;
                4: m_imr = bus_wdata;
                default: ;
            endcase
        end else if (bus_wr && m_st == 4) begin
            if (bus_wdata == 8'h20 && m_isr != 0) isr_n[lowbit(m_isr)] = 1'b0;
            else if (bus_wdata[7:3] == 5'b01100) isr_n[bus_wdata[2:0]] = 1'b0;
        end
        if (!rst_n) begin
            m_st = 0; m_lvl = 0; m_iv4 = 0; m_sng = 1; m_lst = 0; m_base = 0;
            irr_n = 0; isr_n = 0; m_imr = 0; vld_exp = 0;
        end
        m_irqq = rst_n ? irq_in : 8'd0;
        m_irr = irr_n;
        m_isr = isr_n;
        @(posedge clk);
        @(negedge clk);
        chk("R8 int_out vs model", {7'd0, int_out}, {7'd0, m_int()});
        chk("R13 vec_vld", {7'd0, vec_vld}, {7'd0, vld_exp});
        if (vld_exp) chk("R7 vec_out vs model", vec_out, vexp);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_a0 = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic ack();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
    endtask

    task automatic setirq(input logic [7:0] v);
        irq_in = v;
        tick();
    endtask

    task automatic rand_phase(input int cycles);
        for (int n = 0; n < cycles; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 45)      setirq(irq_in ^ (8'd1 << $urandom_range(0, 7)));
            else if (r < 65) ack();
            else if (r < 77) wr(1'b0, 8'h20);
            else if (r < 83) wr(1'b0, 8'h60 | 8'($urandom_range(0, 7)));
            else if (r < 88) wr(1'b1, 8'($urandom) & 8'($urandom));
            else             tick();
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED1234);
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state and no interrupt before configuration
        chk("R1 int after reset", {7'd0, int_out}, 8'd0);
        chk("R1 vld after reset", {7'd0, vec_vld}, 8'd0);
        setirq(8'h01);
        chk("R1 int while unconfigured", {7'd0, int_out}, 8'd0);

        // R2: single, no last word, edge, 8-byte; bits 7:5 set and ignored
        wr(1'b0, 8'hF2);
        chk("R2 int during config", {7'd0, int_out}, 8'd0);
        wr(1'b1, 8'h40);
        chk("R3 ready after two words, R4 held input no edge", {7'd0, int_out}, 8'd0);
        setirq(8'h00);
        setirq(8'h08);
        chk("R4 edge raises int", {7'd0, int_out}, 8'd1);
        ack(); chk("R7 vector irq3 8-byte", vec_out, 8'h43);
        chk("R8 in service blocks", {7'd0, int_out}, 8'd0);
        setirq(8'h28);
        chk("R8 lower priority held off", {7'd0, int_out}, 8'd0);
        setirq(8'h2A);
        chk("R8 higher priority nests", {7'd0, int_out}, 8'd1);
        ack(); chk("R6 vector irq1", vec_out, 8'h41);
        wr(1'b0, 8'h20);
        chk("R9 nonspec clears irq1 only", {7'd0, int_out}, 8'd0);
        wr(1'b0, 8'h63);
        chk("R10 specific clears irq3", {7'd0, int_out}, 8'd1);
        wr(1'b1, 8'h20);
        chk("R11 mask blocks irq5", {7'd0, int_out}, 8'd0);
        wr(1'b1, 8'h00);
        chk("R11 unmask passes irq5", {7'd0, int_out}, 8'd1);
        ack(); chk("R6 vector irq5", vec_out, 8'h45);
        ack(); chk("R12 spurious vector", vec_out, 8'h47);
        wr(1'b0, 8'h20);
        chk("R4 held input no re-request", {7'd0, int_out}, 8'd0);

        // R3: cascaded, level, 4-byte interval, last word present
        setirq(8'h04);
        wr(1'b0, 8'h1D);
        wr(1'b1, 8'hA0);
        chk("R3 cascade waits for extra word", {7'd0, int_out}, 8'd0);
        wr(1'b1, 8'h04);
        chk("R3 waits for last word", {7'd0, int_out}, 8'd0);
        wr(1'b1, 8'h01);
        chk("R5 level request after config", {7'd0, int_out}, 8'd1);
        ack(); chk("R7 vector irq2 4-byte", vec_out, 8'hA8);
        wr(1'b0, 8'h20);
        chk("R5 level re-requests after eoi", {7'd0, int_out}, 8'd1);
        rand_phase(2500);

        // Single with last word, edge mode, then random
        irq_in = 8'h00;
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h88);
        chk("R3 single waits for last word", {7'd0, int_out}, 8'd0);
        wr(1'b1, 8'h00);
        setirq(8'h80);
        chk("R3 ready after three words", {7'd0, int_out}, 8'd1);
        rand_phase(2500);

        done = 1'b1;
        report();
        $finish;
    end
endmodule